// File: doc/BRIEF.md
# SMBus Indexed Block Register Target

This block is a serial management target that keeps a small bank of 8-bit configuration registers for the rest of the chip. A host reaches it over a two-wire open-drain bus. The block never drives SCL. It watches SCL and SDA, and pulls SDA low through an enable output whenever it acknowledges or sends a zero bit.

Each access uses an indexed block transfer. For a write, the host sends three bytes: the target address, a starting index, and a byte count. It then sends exactly that many data bytes, which land in consecutive registers. For a read, the host first sets the index with a write-addressed preamble. It then issues a repeated start and the read address. The target answers with the value of its byte-count register and then streams registers from the index onward. The host acknowledges each byte except the last.

A few upper bits of register 0 are read-only and mirror the frequency-select inputs. The whole bank, including those mirrored bits, is presented as one flat vector for the surrounding logic.

Top module: `smb_regbank`

## Requirements
- R1: The target acknowledges only the address bytes 0xD2 (write) and 0xD3 (read). Any other address byte gets no acknowledge, and the rest of that transfer is ignored.
- R2: In a write, the index byte and then the count byte are each acknowledged. Each data byte within the count is acknowledged and stored at the current index, and the index then advances by one.
- R3: Any data byte beyond the announced count is not acknowledged and is not stored. With a count of zero, the first data byte is already refused.
- R4: In a read, the first byte returned after 0xD3 is the byte-count register. It is followed by the registers at index N, N+1 and onward, one per byte the host acknowledges.
- R5: When the host does not acknowledge a read byte, the target stops transmitting and leaves SDA released for the rest of the transfer.
- R6: Register 12 is the byte-count register, with the count in bits 5:0. A written count above 32 is stored as 32, bits 7:6 always read 0, and its reset value is 0x0D.
- R7: Bits 7:5 of register 0 always show the frequency-select input, with input bit 2 at bit 7. Written values for those bits are discarded, while bits 4:0 are writable.
- R8: Index positions 13 and above read as 0x00. Writes there are acknowledged but change nothing.
- R9: A START or STOP that arrives partway through a byte abandons the transfer without storing anything. A START begins a new address phase at once.
- R10: The SDA pull-down changes only while SCL is low, and it is released after a STOP.
- R11: After reset every register is 0x00 except register 12 (0x0D), and SDA is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Sensed level of the bus clock line |
| sdaIn | input | 1 | Sensed level of the bus data line |
| sdaDriveLow | output | 1 | High to pull the data line low |
| freqSel | input | 3 | Frequency-select inputs mirrored into register 0 bits 7:5 |
| regFlat | output | NUM_REGS*8 | Register bank, register i at bits i*8+7 down to i*8 |

## Verification
Two things can land on the same clock cycle. A bus START or STOP can arrive while the bit engine is partway through shifting in a byte. Separately, the check of the remaining byte budget coincides with the store of the byte that would exceed it. The bench provokes the first by sending a START after four address bits, and a STOP after three data bits. It judges the result by the next full transfer succeeding with every register unchanged. It provokes the second by sending one more byte than announced. That byte must see no acknowledge and leave the register untouched.

// File: rtl/smb_pkg.sv
package smb_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_INDEX,
    PH_COUNT,
    PH_WDATA,
    PH_RDATA
  } phase_e;

  // Strobes from the bus controller to the register datapath
  typedef struct packed {
    logic rxShift;    // take one received bit
    logic setIndex;   // received byte becomes the register index
    logic setBudget;  // received byte becomes the write byte budget
    logic storeByte;  // write received byte at index, advance index
    logic loadCount;  // load transmit shifter with the byte-count register
    logic loadData;   // load transmit shifter from index, advance index
    logic txShift;    // move next transmit bit to the top
  } dpCmd_t;

endpackage

// File: rtl/smb_link.sv
module smb_link
  import smb_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h69
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [7:0] rxByte,
  input  logic       txMsb,
  input  logic       budgetLeft,
  output dpCmd_t     cmd,
  output logic       rxBit,
  output logic       sdaDriveLow
);

  localparam logic [3:0] BYTE_DONE = 4'd8;
  localparam logic [3:0] ACK_SLOT  = 4'd9;

  logic [1:0] sclSync, sdaSync;
  logic       sclPrev, sdaPrev;
  logic       sclS, sdaS;

  assign sclS = sclSync[1];
  assign sdaS = sdaSync[1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclSync <= 2'b11;
      sdaSync <= 2'b11;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSync <= {sclSync[0], sclIn};
      sdaSync <= {sdaSync[0], sdaIn};
      sclPrev <= sclS;
      sdaPrev <= sdaS;
    end
  end

  logic sclRise, sclFall, startEv, stopEv;
  assign sclRise = sclS & ~sclPrev;
  assign sclFall = ~sclS & sclPrev;
  assign startEv = sclS & sclPrev & sdaPrev & ~sdaS;
  assign stopEv  = sclS & sclPrev & ~sdaPrev & sdaS;
  assign rxBit   = sdaS;

  phase_e     phase, phaseN;
  logic [3:0] bitCnt, bitCntN;
  logic       ackLow, ackLowN, txEn, txEnN, hostAck, hostAckN;

  always_comb begin
    phaseN   = phase;
    bitCntN  = bitCnt;
    ackLowN  = ackLow;
    txEnN    = txEn;
    hostAckN = hostAck;
    cmd      = '0;
    if (startEv) begin
      phaseN  = PH_ADDR;
      bitCntN = '0;
      ackLowN = 1'b0;
      txEnN   = 1'b0;
    end else if (stopEv) begin
      phaseN  = PH_IDLE;
      bitCntN = '0;
      ackLowN = 1'b0;
      txEnN   = 1'b0;
    end else if (phase == PH_RDATA) begin
      if (sclRise) begin
        if (bitCnt < BYTE_DONE) bitCntN = bitCnt + 4'd1;
        else if (bitCnt == ACK_SLOT) hostAckN = ~sdaS;
      end
      if (sclFall) begin
        if (bitCnt == BYTE_DONE) begin
          txEnN   = 1'b0;
          bitCntN = ACK_SLOT;
        end else if (bitCnt == ACK_SLOT) begin
          bitCntN = '0;
          if (hostAck) begin
            cmd.loadData = 1'b1;
            txEnN        = 1'b1;
          end else begin
            phaseN = PH_IDLE;
          end
        end else if (bitCnt != 4'd0) begin
          cmd.txShift = 1'b1;
        end
      end
    end else if (phase != PH_IDLE) begin
      if (sclRise && bitCnt < BYTE_DONE) begin
        cmd.rxShift = 1'b1;
        bitCntN     = bitCnt + 4'd1;
      end
      if (sclFall && bitCnt == BYTE_DONE) begin
        ackLowN = 1'b1;
        bitCntN = ACK_SLOT;
        case (phase)
          PH_ADDR: if (rxByte[7:1] != DEV_ADDR) begin
            ackLowN = 1'b0;
            phaseN  = PH_IDLE;
            bitCntN = '0;
          end
          PH_INDEX: cmd.setIndex  = 1'b1;
          PH_COUNT: cmd.setBudget = 1'b1;
          default: if (budgetLeft) cmd.storeByte = 1'b1;
            else begin
              ackLowN = 1'b0;
              phaseN  = PH_IDLE;
              bitCntN = '0;
            end
        endcase
      end else if (sclFall && bitCnt == ACK_SLOT) begin
        ackLowN = 1'b0;
        bitCntN = '0;
        case (phase)
          PH_ADDR: if (rxByte[0]) begin
            phaseN        = PH_RDATA;
            cmd.loadCount = 1'b1;
            txEnN         = 1'b1;
          end else begin
            phaseN = PH_INDEX;
          end
          PH_INDEX: phaseN = PH_COUNT;
          PH_COUNT: phaseN = PH_WDATA;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      bitCnt  <= '0;
      ackLow  <= 1'b0;
      txEn    <= 1'b0;
      hostAck <= 1'b0;
    end else begin
      phase   <= phaseN;
      bitCnt  <= bitCntN;
      ackLow  <= ackLowN;
      txEn    <= txEnN;
      hostAck <= hostAckN;
    end
  end

  assign sdaDriveLow = ackLow | (txEn & ~txMsb);

endmodule

// File: rtl/smb_regfile.sv
module smb_regfile
  import smb_pkg::*;
#(
  parameter int         NUM_REGS = 13,
  parameter int         CNT_IDX  = 12,
  parameter int         CNT_MAX  = 32,
  parameter logic [7:0] CNT_RST  = 8'h0D,
  parameter int         RO_W     = 3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  dpCmd_t                cmd,
  input  logic                  rxBit,
  input  logic [RO_W-1:0]       freqSel,
  output logic [7:0]            rxByte,
  output logic                  txMsb,
  output logic                  budgetLeft,
  output logic [NUM_REGS*8-1:0] regFlat
);

  localparam int         IDX_W   = $clog2(NUM_REGS);
  localparam int         CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [7:0] RW_MASK = 8'hFF >> RO_W;

  logic [7:0] regs [NUM_REGS];
  logic [7:0] idx, budget, rxSh, txSh;

  function automatic logic [7:0] readVal(input logic [7:0] i);
    if (int'(i) >= NUM_REGS) return 8'h00;
    if (i == 8'd0) return {freqSel, regs[0][7-RO_W:0]};
    return regs[i[IDX_W-1:0]];
  endfunction

  function automatic logic [7:0] storeVal(input int r, input logic [7:0] v);
    logic [7:0]       res;
    logic [CNT_W-1:0] fld;
    res = v;
    if (r == CNT_IDX) begin
      fld = v[CNT_W-1:0];
      res = '0;
      res[CNT_W-1:0] = (fld > CNT_W'(CNT_MAX)) ? CNT_W'(CNT_MAX) : fld;
    end else if (r == 0) begin
      res = v & RW_MASK;
    end
    return res;
  endfunction

  function automatic logic [7:0] nextIdx(input logic [7:0] i);
    return (i == 8'hFF) ? i : i + 8'd1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int r = 0; r < NUM_REGS; r++) regs[r] <= (r == CNT_IDX) ? CNT_RST : 8'h00;
      idx    <= '0;
      budget <= '0;
      rxSh   <= '0;
      txSh   <= 8'hFF;
    end else begin
      if (cmd.rxShift)   rxSh   <= {rxSh[6:0], rxBit};
      if (cmd.setIndex)  idx    <= rxSh;
      if (cmd.setBudget) budget <= rxSh;
      if (cmd.storeByte) begin
        for (int r = 0; r < NUM_REGS; r++)
          if (int'(idx) == r) regs[r] <= storeVal(r, rxSh);
        idx    <= nextIdx(idx);
        budget <= budget - 8'd1;
      end
      if (cmd.loadCount) txSh <= readVal(8'(CNT_IDX));
      if (cmd.loadData) begin
        txSh <= readVal(idx);
        idx  <= nextIdx(idx);
      end
      if (cmd.txShift) txSh <= {txSh[6:0], 1'b1};
    end
  end

  assign rxByte     = rxSh;
  assign txMsb      = txSh[7];
  assign budgetLeft = (budget != 8'd0);

  for (genvar g = 0; g < NUM_REGS; g++) begin : gFlat
    if (g == 0) begin : gRo
      assign regFlat[7:0] = {freqSel, regs[0][7-RO_W:0]};
    end else begin : gRw
      assign regFlat[g*8 +: 8] = regs[g];
    end
  end

endmodule

// File: rtl/smb_regbank.sv
module smb_regbank
  import smb_pkg::*;
#(
  parameter int         NUM_REGS = 13,
  parameter int         CNT_IDX  = 12,
  parameter int         CNT_MAX  = 32,
  parameter logic [7:0] CNT_RST  = 8'h0D,
  parameter int         RO_W     = 3,
  parameter logic [6:0] DEV_ADDR = 7'h69
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sclIn,
  input  logic                  sdaIn,
  output logic                  sdaDriveLow,
  input  logic [RO_W-1:0]       freqSel,
  output logic [NUM_REGS*8-1:0] regFlat
);

  dpCmd_t     cmd;
  logic [7:0] rxByte;
  logic       txMsb, budgetLeft, rxBit;

  smb_link #(.DEV_ADDR(DEV_ADDR)) uLink (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .rxByte(rxByte), .txMsb(txMsb), .budgetLeft(budgetLeft),
    .cmd(cmd), .rxBit(rxBit), .sdaDriveLow(sdaDriveLow)
  );

  smb_regfile #(
    .NUM_REGS(NUM_REGS), .CNT_IDX(CNT_IDX), .CNT_MAX(CNT_MAX),
    .CNT_RST(CNT_RST), .RO_W(RO_W)
  ) uRegs (
    .clk(clk), .rstN(rstN), .cmd(cmd), .rxBit(rxBit), .freqSel(freqSel),
    .rxByte(rxByte), .txMsb(txMsb), .budgetLeft(budgetLeft), .regFlat(regFlat)
  );

endmodule

// File: rtl/smb_regbank_chk.sv
module smb_regbank_chk #(
  parameter int NUM_REGS = 13,
  parameter int CNT_IDX  = 12,
  parameter int CNT_MAX  = 32
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  sclIn,
  input logic                  sdaIn,
  input logic                  sdaDriveLow,
  input logic [NUM_REGS*8-1:0] regFlat
);

  logic [1:0] sclQ, sdaQ;
  logic       sclP, sdaP;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclQ <= 2'b11;
      sdaQ <= 2'b11;
      sclP <= 1'b1;
      sdaP <= 1'b1;
    end else begin
      sclQ <= {sclQ[0], sclIn};
      sdaQ <= {sdaQ[0], sdaIn};
      sclP <= sclQ[1];
      sdaP <= sdaQ[1];
    end
  end

  logic seenStart, seenStop;
  assign seenStart = sclQ[1] & sclP & sdaP & ~sdaQ[1];
  assign seenStop  = sclQ[1] & sclP & ~sdaP & sdaQ[1];

  AST_PULL_ONLY_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaDriveLow) |-> !sclQ[1]) else $error("pull-down began with SCL high"); // R10
  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
    seenStop |=> !sdaDriveLow) else $error("SDA held after STOP"); // R10
  AST_START_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
    seenStart |=> !sdaDriveLow) else $error("SDA held after START"); // R9
  AST_COUNT_CAP: assert property (@(posedge clk) disable iff (!rstN)
    regFlat[CNT_IDX*8 +: 8] <= 8'(CNT_MAX)) else $error("byte count above cap"); // R6

endmodule

bind smb_regbank smb_regbank_chk #(
  .NUM_REGS(NUM_REGS), .CNT_IDX(CNT_IDX), .CNT_MAX(CNT_MAX)
) uChk (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
  .sdaDriveLow(sdaDriveLow), .regFlat(regFlat)
);

// File: tb/tb_smb_regbank.sv
module tb_smb_regbank;
  localparam int NUM_REGS = 13;
  localparam int CNT_IDX  = 12;
  localparam int Q        = 4;

  logic       clk = 1'b0, rstN = 1'b0, scl = 1'b1, sdaHost = 1'b1;
  logic [2:0] freqSel = 3'b101;
  wire        sdaDriveLow;
  wire [NUM_REGS*8-1:0] regFlat;
  wire        sdaBus = sdaHost & ~sdaDriveLow;

  always #10 clk = ~clk;

  smb_regbank dut (
    .clk(clk), .rstN(rstN), .sclIn(scl), .sdaIn(sdaBus),
    .sdaDriveLow(sdaDriveLow), .freqSel(freqSel), .regFlat(regFlat)
  );

  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] model [NUM_REGS];
  logic [7:0] wbuf [8];
  logic [7:0] rbuf [9];
  logic       ackLog [12];
  logic       relAfterNack;

  function automatic logic [7:0] expRead(input int i);
    if (i >= NUM_REGS) return 8'h00;
    if (i == 0) return {freqSel, model[0][4:0]};
    return model[i];
  endfunction

  function automatic logic [7:0] expStore(input int i, input logic [7:0] v);
    if (i == CNT_IDX) return (v[5:0] > 6'd32) ? 8'd32 : {2'b00, v[5:0]};
    if (i == 0) return {3'b000, v[4:0]};
    return v;
  endfunction

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic busStart();
    sdaHost = 1'b1; ticks(2*Q); scl = 1'b1; ticks(2*Q);
    sdaHost = 1'b0; ticks(2*Q); scl = 1'b0;
  endtask

  task automatic busStop();
    sdaHost = 1'b0; ticks(2*Q); scl = 1'b1; ticks(2*Q);
    sdaHost = 1'b1; ticks(2*Q);
  endtask

  task automatic bitOut(input logic b);
    sdaHost = b; ticks(2*Q); scl = 1'b1; ticks(2*Q); scl = 1'b0;
  endtask

  task automatic bitIn(output logic b);
    sdaHost = 1'b1; ticks(2*Q); scl = 1'b1; ticks(Q);
    b = sdaBus; ticks(Q); scl = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] v, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) bitOut(v[i]);
    bitIn(a);
    ack = ~a;
  endtask

  task automatic recvByte(input logic ackIt, output logic [7:0] v);
    for (int i = 7; i >= 0; i--) bitIn(v[i]);
    bitOut(~ackIt);
  endtask

  task automatic doWrite(input logic [7:0] addr, input logic [7:0] idx,
                         input logic [7:0] cnt, input int nSend);
    busStart();
    sendByte(addr, ackLog[0]);
    sendByte(idx, ackLog[1]);
    sendByte(cnt, ackLog[2]);
    for (int k = 0; k < nSend; k++) sendByte(wbuf[k], ackLog[3+k]);
    busStop();
  endtask

  task automatic applyModel(input int idx, input int cnt, input int nSend);
    for (int k = 0; k < cnt && k < nSend; k++)
      if (idx + k < NUM_REGS) model[idx+k] = expStore(idx + k, wbuf[k]);
  endtask

  task automatic doRead(input logic [7:0] idx, input int n);
    busStart();
    sendByte(8'hD2, ackLog[0]);
    sendByte(idx, ackLog[1]);
    busStart();
    sendByte(8'hD3, ackLog[2]);
    for (int k = 0; k <= n; k++) recvByte(k != n, rbuf[k]);
    ticks(2*Q);
    relAfterNack = ~sdaDriveLow;
    busStop();
  endtask

  task automatic checkRead(input string tag, input int idx, input int n);
    chk({tag, " read acks"}, {ackLog[0], ackLog[1], ackLog[2]}, 3'b111);
    chk({tag, " R4 count byte"}, rbuf[0], expRead(CNT_IDX));
    for (int k = 0; k < n; k++) chk({tag, " R4 data byte"}, rbuf[k+1], expRead(idx + k));
  endtask

  task automatic checkFlat(input string tag);
    for (int i = 0; i < NUM_REGS; i++) chk(tag, regFlat[i*8 +: 8], expRead(i));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic b;
    void'($urandom(32'h5EED));
    for (int i = 0; i < NUM_REGS; i++) model[i] = (i == CNT_IDX) ? 8'h0D : 8'h00;
    ticks(5);
    rstN = 1'b1;
    ticks(5);

    // R11 reset state
    checkFlat("R11 reset register");
    chk("R11 SDA released", sdaDriveLow, 1'b0);

    // R1 foreign address refused
    wbuf[0] = 8'h55;
    doWrite(8'hA0, 8'd1, 8'd1, 1);
    chk("R1 foreign address nack", ackLog[0], 1'b0);
    chk("R1 no store after nack", regFlat[15:8], 8'h00);

    // R7 read-only frequency bits
    wbuf[0] = 8'hFF;
    doWrite(8'hD2, 8'd0, 8'd1, 1);
    applyModel(0, 1, 1);
    chk("R7 reg0 after write", regFlat[7:0], {3'b101, 5'h1F});
    freqSel = 3'b010;
    ticks(4);
    chk("R7 reg0 follows input", regFlat[7:0], {3'b010, 5'h1F});
    doRead(8'd0, 1);
    checkRead("R7", 0, 1);

    // R6 count clamp and reserved bits
    wbuf[0] = 8'h3F;
    doWrite(8'hD2, 8'd12, 8'd1, 1);
    applyModel(12, 1, 1);
    chk("R6 clamp to 32", regFlat[CNT_IDX*8 +: 8], 8'h20);
    doRead(8'd3, 2);
    checkRead("R6", 3, 2);
    wbuf[0] = 8'hC5;
    doWrite(8'hD2, 8'd12, 8'd1, 1);
    applyModel(12, 1, 1);
    chk("R6 reserved bits zero", regFlat[CNT_IDX*8 +: 8], 8'h05);

    // R8 beyond last register
    wbuf[0] = 8'h11; wbuf[1] = 8'h22;
    doWrite(8'hD2, 8'd12, 8'd2, 2);
    applyModel(12, 2, 2);
    chk("R8 write past end acked", ackLog[4], 1'b1);
    checkFlat("R8 bank after write past end");
    doRead(8'd12, 3);
    checkRead("R8", 12, 3);

    // R3 more bytes than announced
    wbuf[0] = 8'h5A; wbuf[1] = 8'hA5;
    doWrite(8'hD2, 8'd3, 8'd1, 2);
    applyModel(3, 1, 2);
    chk("R3 byte in budget acked", ackLog[3], 1'b1);
    chk("R3 extra byte nacked", ackLog[4], 1'b0);
    chk("R3 extra byte not stored", regFlat[4*8 +: 8], 8'h00);
    wbuf[0] = 8'h99;
    doWrite(8'hD2, 8'd5, 8'd0, 1);
    chk("R3 zero count nack", ackLog[3], 1'b0);
    chk("R3 zero count no store", regFlat[5*8 +: 8], 8'h00);

    // R9 START mid-address, STOP mid-data
    busStart();
    for (int i = 0; i < 4; i++) bitOut(1'b1);
    wbuf[0] = 8'h77;
    doWrite(8'hD2, 8'd7, 8'd1, 1);
    applyModel(7, 1, 1);
    chk("R9 write after START abort", {ackLog[0], ackLog[3]}, 2'b11);
    busStart();
    sendByte(8'hD2, b); sendByte(8'd7, b); sendByte(8'd1, b);
    for (int i = 0; i < 3; i++) bitOut(1'b0);
    busStop();
    checkFlat("R9 bank after STOP abort");
    chk("R9 SDA free after abort", sdaDriveLow, 1'b0);

    // R5 host NACK ends transmit (next byte would be 0x00)
    doRead(8'd12, 1);
    checkRead("R5", 12, 1);
    chk("R5 released after host nack", relAfterNack, 1'b1);
    chk("R10 released after stop", sdaDriveLow, 1'b0);

    // R2 randomised block writes and reads
    for (int it = 0; it < 20; it++) begin
      int idx, cnt, n;
      idx = $urandom_range(0, 14);
      cnt = $urandom_range(0, 4);
      for (int k = 0; k < cnt; k++) wbuf[k] = 8'($urandom);
      if (it % 5 == 4) freqSel = 3'($urandom);
      doWrite(8'hD2, 8'(idx), 8'(cnt), cnt);
      applyModel(idx, cnt, cnt);
      chk("R2 header acks", {ackLog[0], ackLog[1], ackLog[2]}, 3'b111);
      for (int k = 0; k < cnt; k++) chk("R2 data ack", ackLog[3+k], 1'b1);
      checkFlat("R2 bank contents");
      n = $urandom_range(1, 4);
      doRead(8'(idx), n);
      checkRead("R2 R4", idx, n);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule